// File: doc/BRIEF.md
# Strobed Output Handshake Controller

This block runs the handshake that hands processor bytes to an asynchronous peripheral over an 8-bit parallel port (port A). The peripheral answers each byte with an active-low acknowledge strobe on pin 7 of a second port (port B). The block drives an active-low buffer-full flag on port B pin 6 and an interrupt request toward the processor. It takes in bus events that were decoded elsewhere: the end of a byte write to port A, single-bit set/clear writes, byte writes to port B and mode-register writes. It also takes the raw acknowledge pin and the port A direction bits. From these it produces the flag, the interrupt and the per-pin output enables for port A.

There are two strobed variants, chosen by one mode-register bit. In the continuous variant, port A drives its output-direction pins at all times. In the tri-state variant, those pins float and are driven only while the synchronized acknowledge is low. The acknowledge pin is synchronized with a two-flop chain before it is used. Each edge of it takes effect after that latency.

Top module: `strobe_out_hs`

## Requirements
- R1: While rst is high and on the first cycle after it, obf_n is 1, intr is 0 and hs_drive is 0. Basic mode is active, so pa_oe equals pa_dir.
- R2: A mode write with mode_data[6:5] = 2'b11 enters a strobed output mode: continuous when mode_data[7] = 0, tri-state when mode_data[7] = 1. On the next cycle hs_drive is 1, obf_n is 1 and the interrupt latch is set.
- R3: In a strobed mode, a pa_wr_done pulse drives obf_n to 0 and intr to 0 on the next cycle.
- R4: In a strobed mode, a falling edge on ack_n sets obf_n to 1 on the third rising clock edge after the pin changes.
- R5: In a strobed mode, a rising edge on ack_n sets the interrupt latch on the third rising clock edge after the pin changes.
- R6: intr equals the interrupt latch ANDed with the interrupt enable. The enable is changed by a bit write with bit_port = 1 (port B) and bit_idx = 7, where bit_set gives the new value.
- R7: A bit write with bit_port = 1 and bit_idx = 6 sets obf_n to bit_set on the next cycle, in any mode.
- R8: A port B byte write (pb_wr) loads pb_wdata[7] into the interrupt enable and pb_wdata[6] into obf_n only when no strobed mode is active. In a strobed mode it changes neither.
- R9: Bit writes to port A (bit_port = 0) and bit writes to port B pins 0 to 5 leave obf_n and intr unchanged. pa_oe is never 1 on a pin whose pa_dir bit is 0.
- R10: In basic mode and in the continuous strobed mode, pa_oe equals pa_dir whatever ack_n does.
- R11: In the tri-state mode, pa_oe is 0 while the synchronized acknowledge is high. It equals pa_dir from the second rising edge after ack_n falls until the second rising edge after ack_n rises.
- R12: A mode write whose bits 6:5 are not 2'b11 leaves the strobed modes. On the next cycle hs_drive is 0, intr is 0, and from then on acknowledge edges and pa_wr_done do not change obf_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle pulse: mode-register write |
| mode_data | input | 8 | Mode value written; bits 6:5 = 11 select strobed output, bit 7 selects tri-state |
| pa_wr_done | input | 1 | One-cycle pulse: end of a processor byte write to port A |
| bit_wr | input | 1 | One-cycle pulse: single-bit set/clear write |
| bit_port | input | 1 | Port of the bit write: 0 = A, 1 = B |
| bit_idx | input | 3 | Pin index of the bit write |
| bit_set | input | 1 | 1 = set, 0 = clear |
| pb_wr | input | 1 | One-cycle pulse: byte write to port B |
| pb_wdata | input | 8 | Port B byte write data |
| ack_n | input | 1 | Asynchronous active-low acknowledge from the peripheral (port B pin 7) |
| pa_dir | input | 8 | Port A direction bits, 1 = output |
| obf_n | output | 1 | Active-low buffer-full flag (port B pin 6 value) |
| intr | output | 1 | Interrupt request, active high |
| hs_drive | output | 1 | 1 while a strobed output mode drives pin 6 and the interrupt |
| pa_oe | output | 8 | Port A per-pin output enables |

## Verification
The assertions assume that the decoded bus events are one-cycle pulses. They also assume that a port A byte-write end never lands in the same cycle as a mode write. Finally, they assume that rst is asserted before the first checked edge. The bench drives each event at the falling clock edge and releases it one cycle later. It keeps the events of different kinds in separate cycles, and it holds ack_n stable for several cycles between edges, so every edge passes through the synchronizer cleanly.

// File: rtl/strobe_out_pkg.sv
package strobe_out_pkg;
  localparam int MODE_W      = 8;
  localparam int MODE_OUT_LO = 5;
  localparam int MODE_OUT_HI = 6;
  localparam int MODE_TRI    = 7;
  localparam int OBF_PIN     = 6;
  localparam int ACK_PIN     = 7;

  typedef enum logic [1:0] {
    HS_BASIC = 2'd0,
    HS_CONT  = 2'd1,
    HS_TRI   = 2'd2
  } hs_mode_e;

  function automatic hs_mode_e decode_mode(input logic [MODE_W-1:0] v);
    if (v[MODE_OUT_HI] && v[MODE_OUT_LO])
      return v[MODE_TRI] ? HS_TRI : HS_CONT;
    return HS_BASIC;
  endfunction
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign low  = ~chain[STAGES-1];
  assign fell = prev & ~chain[STAGES-1];
  assign rose = ~prev & chain[STAGES-1];
endmodule

// File: rtl/hs_flags.sv
module hs_flags
  import strobe_out_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              pa_wr_done,
  input  logic              bit_wr,
  input  logic              bit_port,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_set,
  input  logic              pb_wr,
  input  logic [MODE_W-1:0] pb_wdata,
  input  logic              ack_fell,
  input  logic              ack_rose,
  output hs_mode_e          mode,
  output logic              obf_n,
  output logic              intr
);
  logic irq_latch;
  logic irq_en;
  logic strobed;
  hs_mode_e next_mode;

  assign strobed   = (mode != HS_BASIC);
  assign next_mode = decode_mode(mode_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= HS_BASIC;
      obf_n     <= 1'b1;
      irq_latch <= 1'b0;
      irq_en    <= 1'b0;
    end else begin
      if (strobed && ack_fell) obf_n <= 1'b1;
      if (strobed && ack_rose) irq_latch <= 1'b1;
      if (pb_wr && !strobed) begin
        irq_en <= pb_wdata[ACK_PIN];
        obf_n  <= pb_wdata[OBF_PIN];
      end
      if (bit_wr && bit_port) begin
        if (bit_idx == IDX_W'(ACK_PIN)) irq_en <= bit_set;
        if (bit_idx == IDX_W'(OBF_PIN)) obf_n  <= bit_set;
      end
      if (strobed && pa_wr_done) begin
        obf_n     <= 1'b0;
        irq_latch <= 1'b0;
      end
      if (mode_wr) begin
        mode      <= next_mode;
        irq_latch <= (next_mode != HS_BASIC);
        if (next_mode != HS_BASIC) obf_n <= 1'b1;
      end
    end
  end

  assign intr = strobed & irq_latch & irq_en;
endmodule

// File: rtl/pa_drive.sv
module pa_drive
  import strobe_out_pkg::*;
#(
  parameter int W = 8
) (
  input  hs_mode_e     mode,
  input  logic         ack_low,
  input  logic [W-1:0] dir,
  output logic [W-1:0] oe
);
  logic gate;
  assign gate = (mode != HS_TRI) | ack_low;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe[i] = dir[i] & gate;
  end
endmodule

// File: rtl/strobe_out_hs.sv
module strobe_out_hs
  import strobe_out_pkg::*;
#(
  parameter int PA_W        = 8,
  parameter int IDX_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              pa_wr_done,
  input  logic              bit_wr,
  input  logic              bit_port,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_set,
  input  logic              pb_wr,
  input  logic [MODE_W-1:0] pb_wdata,
  input  logic              ack_n,
  input  logic [PA_W-1:0]   pa_dir,
  output logic              obf_n,
  output logic              intr,
  output logic              hs_drive,
  output logic [PA_W-1:0]   pa_oe
);
  logic     ack_low, ack_fell, ack_rose;
  hs_mode_e mode;

  ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(ack_n),
    .low(ack_low), .fell(ack_fell), .rose(ack_rose)
  );

  hs_flags #(.IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_data(mode_data),
    .pa_wr_done(pa_wr_done), .bit_wr(bit_wr), .bit_port(bit_port),
    .bit_idx(bit_idx), .bit_set(bit_set), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .ack_fell(ack_fell), .ack_rose(ack_rose),
    .mode(mode), .obf_n(obf_n), .intr(intr)
  );

  pa_drive #(.W(PA_W)) u_drive (
    .mode(mode), .ack_low(ack_low), .dir(pa_dir), .oe(pa_oe)
  );

  assign hs_drive = (mode != HS_BASIC);
endmodule

// File: rtl/strobe_out_hs_chk.sv
module strobe_out_hs_chk #(
  parameter int PA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mode_wr,
  input logic [7:0]      mode_data,
  input logic            pa_wr_done,
  input logic            obf_n,
  input logic            intr,
  input logic            hs_drive,
  input logic [PA_W-1:0] pa_dir,
  input logic [PA_W-1:0] pa_oe
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (obf_n && !intr && !hs_drive));

  a_r2_mode_entry: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_wr) && $past(mode_data[6:5]) == 2'b11) |-> (obf_n && hs_drive));

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(pa_wr_done) && $past(hs_drive) && !$past(mode_wr)) |-> (!obf_n && !intr));

  a_r9_oe_within_dir: assert property (@(posedge clk) disable iff (rst)
    (pa_oe & ~pa_dir) == '0);

  a_r12_no_intr_basic: assert property (@(posedge clk) disable iff (rst)
    !hs_drive |-> !intr);

  a_r12_mode_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_wr) && $past(mode_data[6:5]) != 2'b11) |-> (!hs_drive && !intr));
endmodule

bind strobe_out_hs strobe_out_hs_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_data(mode_data),
  .pa_wr_done(pa_wr_done), .obf_n(obf_n), .intr(intr), .hs_drive(hs_drive),
  .pa_dir(pa_dir), .pa_oe(pa_oe)
);

// File: tb/strobe_out_hs_tb.sv
module strobe_out_hs_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_wr, pa_wr_done, bit_wr, bit_port, bit_set, pb_wr, ack_n;
  logic [7:0] mode_data, pb_wdata, pa_dir;
  logic [2:0] bit_idx;
  logic       obf_n, intr, hs_drive;
  logic [7:0] pa_oe;
  int         n_checks = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  strobe_out_hs u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_data(mode_data),
    .pa_wr_done(pa_wr_done), .bit_wr(bit_wr), .bit_port(bit_port),
    .bit_idx(bit_idx), .bit_set(bit_set), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .ack_n(ack_n), .pa_dir(pa_dir), .obf_n(obf_n), .intr(intr),
    .hs_drive(hs_drive), .pa_oe(pa_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_data = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic do_pa_write();
    @(negedge clk); pa_wr_done = 1'b1;
    @(negedge clk); pa_wr_done = 1'b0;
  endtask

  task automatic do_bit(input logic port, input logic [2:0] idx, input logic s);
    @(negedge clk); bit_wr = 1'b1; bit_port = port; bit_idx = idx; bit_set = s;
    @(negedge clk); bit_wr = 1'b0;
  endtask

  task automatic do_pb(input logic [7:0] d);
    @(negedge clk); pb_wr = 1'b1; pb_wdata = d;
    @(negedge clk); pb_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(3);
    chk("R1 obf_n in reset", {7'd0, obf_n}, 8'd1);
    chk("R1 intr in reset", {7'd0, intr}, 8'd0);
    rst = 1'b0; tick(1);
    chk("R1 hs_drive after reset", {7'd0, hs_drive}, 8'd0);
    chk("R1 pa_oe basic", pa_oe, pa_dir);
  endtask

  task automatic t_enter_cont();
    do_mode(8'h60);
    chk("R2 hs_drive mode3", {7'd0, hs_drive}, 8'd1);
    chk("R2 obf_n mode3", {7'd0, obf_n}, 8'd1);
    chk("R6 intr gated off by ie=0", {7'd0, intr}, 8'd0);
    do_bit(1'b1, 3'd7, 1'b1);
    chk("R6 intr after ie set (latch preset by R2)", {7'd0, intr}, 8'd1);
  endtask

  task automatic t_cycle_cont();
    do_pa_write();
    chk("R3 obf_n low after write", {7'd0, obf_n}, 8'd0);
    chk("R3 intr low after write", {7'd0, intr}, 8'd0);
    @(negedge clk); ack_n = 1'b0;
    tick(2);
    chk("R4 obf_n still low at 2 edges", {7'd0, obf_n}, 8'd0);
    chk("R10 pa_oe mode3 during ack", pa_oe, pa_dir);
    tick(1);
    chk("R4 obf_n high at 3 edges", {7'd0, obf_n}, 8'd1);
    chk("R5 intr low while ack low", {7'd0, intr}, 8'd0);
    ack_n = 1'b1;
    tick(2);
    chk("R5 intr not yet at 2 edges", {7'd0, intr}, 8'd0);
    tick(1);
    chk("R5 intr set at 3 edges", {7'd0, intr}, 8'd1);
    chk("R10 pa_oe mode3 idle", pa_oe, pa_dir);
  endtask

  task automatic t_overrides();
    do_bit(1'b1, 3'd6, 1'b0);
    chk("R7 obf_n cleared by bit write", {7'd0, obf_n}, 8'd0);
    do_bit(1'b1, 3'd6, 1'b1);
    chk("R7 obf_n set by bit write", {7'd0, obf_n}, 8'd1);
    do_bit(1'b1, 3'd7, 1'b0);
    chk("R6 intr off with ie cleared", {7'd0, intr}, 8'd0);
    do_bit(1'b1, 3'd7, 1'b1);
    chk("R6 intr back with ie set", {7'd0, intr}, 8'd1);
  endtask

  task automatic t_ignored();
    do_pb(8'h00);
    chk("R8 pb write masked obf_n", {7'd0, obf_n}, 8'd1);
    chk("R8 pb write masked ie", {7'd0, intr}, 8'd1);
    do_bit(1'b0, 3'd6, 1'b0);
    do_bit(1'b0, 3'd7, 1'b0);
    do_bit(1'b1, 3'd5, 1'b0);
    do_bit(1'b1, 3'd0, 1'b1);
    chk("R9 obf_n unchanged by other bit ops", {7'd0, obf_n}, 8'd1);
    chk("R9 intr unchanged by other bit ops", {7'd0, intr}, 8'd1);
  endtask

  task automatic t_tri();
    do_mode(8'hE0);
    chk("R2 hs_drive mode4", {7'd0, hs_drive}, 8'd1);
    chk("R11 pa_oe floats idle", pa_oe, 8'h00);
    do_pa_write();
    chk("R3 obf_n low mode4", {7'd0, obf_n}, 8'd0);
    @(negedge clk); ack_n = 1'b0;
    tick(1);
    chk("R11 pa_oe still off at 1 edge", pa_oe, 8'h00);
    tick(1);
    chk("R11 pa_oe on at 2 edges", pa_oe, pa_dir);
    tick(2);
    chk("R4 obf_n high mode4", {7'd0, obf_n}, 8'd1);
    ack_n = 1'b1;
    tick(1);
    chk("R11 pa_oe held at 1 edge after rise", pa_oe, pa_dir);
    tick(1);
    chk("R11 pa_oe off at 2 edges after rise", pa_oe, 8'h00);
    tick(1);
    chk("R5 intr mode4", {7'd0, intr}, 8'd1);
  endtask

  task automatic t_leave();
    do_mode(8'h20);
    chk("R12 hs_drive off", {7'd0, hs_drive}, 8'd0);
    chk("R12 intr off", {7'd0, intr}, 8'd0);
    chk("R10 pa_oe basic after exit", pa_oe, pa_dir);
    do_pa_write();
    chk("R12 write ignored in basic", {7'd0, obf_n}, 8'd1);
    do_pb(8'h00);
    chk("R8 pb write loads obf_n in basic", {7'd0, obf_n}, 8'd0);
    @(negedge clk); ack_n = 1'b0; tick(4);
    chk("R12 ack ignored in basic", {7'd0, obf_n}, 8'd0);
    ack_n = 1'b1; tick(4);
    do_mode(8'h60);
    chk("R8 ie loaded 0 by basic pb write", {7'd0, intr}, 8'd0);
  endtask

  initial begin
    rst = 1'b1; mode_wr = 0; pa_wr_done = 0; bit_wr = 0; bit_port = 0;
    bit_set = 0; bit_idx = 0; pb_wr = 0; ack_n = 1'b1;
    mode_data = 8'h00; pb_wdata = 8'h00; pa_dir = 8'hF0;
    t_reset();
    t_enter_cont();
    t_cycle_cont();
    t_overrides();
    t_ignored();
    t_tri();
    t_leave();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule